// File: doc/BRIEF.md
# Masked Internal Control Register File

This block is an indexed bank of 64-bit privileged control registers, reached through a single port that takes an index, write data and separate read and write strobes. Each index has its own write behaviour, fixed at design time. An index can be plain storage, storage that keeps only some bit fields, a register that any write clears, a register that is read-only or write-only, a one-shot control bit, or a cycle counter. The cycle counter keeps its upper half in storage and takes its lower half from a free-running count input.

An access that the selected index does not allow raises an error flag, and an access that errors changes no state. Write-only indices stand for control actions aimed at neighbouring units: a TLB flush, an instruction cache flush and a data cache flush. The block's only output for each of these is a one-cycle pulse.

The port accepts an access on every cycle and has no back-pressure. `rd_i` and `wr_i` act as the valid qualifiers of the request. The response has no ready input: `rsp_valid_o` marks the cycle in which the read data is due, and the consumer must take it in that cycle.

Top module: `icr_file`

## Requirements
- R1: After reset, every register reads as zero, except index 8 (program base), which reads as the parameter `PAL_BASE_RST`, and index 9 (memory control), which reads as 0x6. `rdata_o`, `rsp_valid_o`, `err_o` and all flush pulses are low.
- R2: An access on `rd_i` causes `rsp_valid_o` to be high in the next cycle, and `err_o` and `rdata_o` are valid in that same cycle. `rdata_o` is zero when the read errors.
- R3: Indices 0 to 9 store all 64 bits of the write data.
- R4: Masked indices keep only these bits of the write data and read all other bits as zero:
  - 11 and 12 keep 0xF.
  - 13 and 14 keep 0x18.
  - 15 keeps 0xFF_FFFF_0300.
  - 16 and 17 keep bits 63 to 30.
  - 18 and 19 keep 0x3F.
  - 20 keeps 0x7F0.
  - 21 keeps bits 63 to 57.
- R5: Index 10 (exception return address) stores the write data with bit 1 forced to zero.
- R6: A write to index 22 or index 23 sets that register to zero, whatever the write data.
- R7: Index 26 (cycle counter) stores bits 63 to 32 of a write. A read of index 26 returns the stored upper half together with the value of `cycle_i` in the access cycle as bits 31 to 0.
- R8: The first write to index 27 sets it to 1, whatever the write data. Any later write to index 27 is an error and leaves it at 1.
- R9: Each of these is an error, reported on `err_o` in the next cycle:
  - a write to index 24 or 25, which are read-only;
  - a read of index 28, 29 or 30, which are write-only;
  - any access to index 31 or above;
  - `rd_i` and `wr_i` high in the same cycle.
  A write that errors changes no register.
- R10: A legal write to index 28, 29 or 30 causes a single-cycle pulse on `tlb_flush_o`, `icache_flush_o` or `dcache_flush_o` respectively, in the next cycle. At most one of these pulses is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idx_i | input | IDX_W | Register index of the access |
| wdata_i | input | 64 | Write data |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| cycle_i | input | 32 | Free-running cycle count |
| rdata_o | output | 64 | Read data, registered |
| rsp_valid_o | output | 1 | Read response due in this cycle |
| err_o | output | 1 | Previous access was illegal |
| tlb_flush_o | output | 1 | TLB flush pulse |
| icache_flush_o | output | 1 | Instruction cache flush pulse |
| dcache_flush_o | output | 1 | Data cache flush pulse |

## Verification
Every result of this block is due exactly one clock edge after the access that causes it. That covers read data, the response strobe, the error flag and the flush pulses. A write becomes visible to a read issued on the following cycle. The bench drives each access on a falling edge and samples all outputs on the next falling edge, half a cycle after the single register stage. On the falling edge after that, it confirms that the response and the flush pulses have dropped again. For the cycle counter, the expected low half is the `cycle_i` value that the bench held during the access cycle.

// File: rtl/icr_pkg.sv
package icr_pkg;

  localparam int DW = 64;
  localparam int CW = 32;

  typedef enum logic [2:0] {
    K_NONE, K_PLAIN, K_CLR, K_RO, K_WO, K_CYC, K_ONCE
  } kind_e;

  localparam int unsigned IX_PAL    = 8;
  localparam int unsigned IX_MEMCTL = 9;
  localparam int unsigned IX_EXCRET = 10;
  localparam int unsigned IX_EXSUM  = 22;
  localparam int unsigned IX_EXMSK  = 23;
  localparam int unsigned IX_INTID  = 24;
  localparam int unsigned IX_MMST   = 25;
  localparam int unsigned IX_CYC    = 26;
  localparam int unsigned IX_CYCCTL = 27;
  localparam int unsigned IX_TLBFL  = 28;
  localparam int unsigned IX_ICFL   = 29;
  localparam int unsigned IX_DCFL   = 30;

  function automatic kind_e kind_of(int unsigned i);
    kind_e k;
    if (i <= 21)                          k = K_PLAIN;
    else if (i == IX_EXSUM || i == IX_EXMSK) k = K_CLR;
    else if (i == IX_INTID || i == IX_MMST)  k = K_RO;
    else if (i == IX_CYC)                 k = K_CYC;
    else if (i == IX_CYCCTL)              k = K_ONCE;
    else if (i >= IX_TLBFL && i <= IX_DCFL) k = K_WO;
    else                                  k = K_NONE;
    return k;
  endfunction

  function automatic logic [DW-1:0] mask_of(int unsigned i);
    logic [DW-1:0] m;
    case (i)
      10:      m = ~64'h2;
      11, 12:  m = 64'hF;
      13, 14:  m = 64'h18;
      15:      m = 64'hFF_FFFF_0300;
      16, 17:  m = 64'hFFFF_FFFF_C000_0000;
      18, 19:  m = 64'h3F;
      20:      m = 64'h7F0;
      21:      m = 64'hFE00_0000_0000_0000;
      26:      m = 64'hFFFF_FFFF_0000_0000;
      default: m = '1;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/icr_slot.sv
module icr_slot
  import icr_pkg::*;
#(
  parameter kind_e         KIND = K_PLAIN,
  parameter logic [DW-1:0] MASK = '1,
  parameter logic [DW-1:0] RSTV = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [DW-1:0] wd,
  output logic [DW-1:0] q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q <= RSTV;
    end else if (we) begin
      case (KIND)
        K_PLAIN, K_CYC: q <= wd & MASK;
        K_CLR:          q <= '0;
        K_ONCE:         q <= DW'(1);
        default:        q <= q;
      endcase
    end
  end

endmodule

// File: rtl/icr_access.sv
module icr_access
  import icr_pkg::*;
(
  input  logic  rd,
  input  logic  wr,
  input  kind_e kind,
  input  logic  once_set,
  output logic  err,
  output logic  commit
);

  logic bad_kind;

  always_comb begin
    bad_kind = 1'b0;
    if ((rd || wr) && kind == K_NONE) bad_kind = 1'b1;
    if (wr && kind == K_RO)           bad_kind = 1'b1;
    if (rd && kind == K_WO)           bad_kind = 1'b1;
    if (wr && kind == K_ONCE && once_set) bad_kind = 1'b1;
    err    = bad_kind || (rd && wr);
    commit = wr && !err;
  end

endmodule

// File: rtl/icr_file.sv
module icr_file
  import icr_pkg::*;
#(
  parameter int            IDX_W        = 6,
  parameter logic [DW-1:0] PAL_BASE_RST = 64'h0000_0000_2000_0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [CW-1:0]    cycle_i,
  output logic [DW-1:0]    rdata_o,
  output logic             rsp_valid_o,
  output logic             err_o,
  output logic             tlb_flush_o,
  output logic             icache_flush_o,
  output logic             dcache_flush_o
);

  localparam int NSLOT = 1 << IDX_W;

  logic [DW-1:0] slot_q [NSLOT];
  kind_e         cur_kind;
  logic          acc_err, acc_commit, once_set;
  logic [DW-1:0] rd_val;

  assign cur_kind = kind_of(int'(idx_i));
  assign once_set = slot_q[IX_CYCCTL][0];

  icr_access u_access (
    .rd       (rd_i),
    .wr       (wr_i),
    .kind     (cur_kind),
    .once_set (once_set),
    .err      (acc_err),
    .commit   (acc_commit)
  );

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    icr_slot #(
      .KIND (kind_of(g)),
      .MASK (mask_of(g)),
      .RSTV ((g == IX_PAL) ? PAL_BASE_RST :
             (g == IX_MEMCTL) ? DW'(6) : '0)
    ) u_slot (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (acc_commit && (idx_i == IDX_W'(g))),
      .wd    (wdata_i),
      .q     (slot_q[g])
    );
  end

  // cycle counter: live low half joins stored high half
  always_comb begin
    rd_val = slot_q[idx_i];
    if (cur_kind == K_CYC) rd_val = {slot_q[idx_i][DW-1:CW], cycle_i};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_o        <= '0;
      rsp_valid_o    <= 1'b0;
      err_o          <= 1'b0;
      tlb_flush_o    <= 1'b0;
      icache_flush_o <= 1'b0;
      dcache_flush_o <= 1'b0;
    end else begin
      rsp_valid_o    <= rd_i;
      err_o          <= acc_err;
      if (rd_i) rdata_o <= acc_err ? '0 : rd_val;
      tlb_flush_o    <= acc_commit && (idx_i == IDX_W'(IX_TLBFL));
      icache_flush_o <= acc_commit && (idx_i == IDX_W'(IX_ICFL));
      dcache_flush_o <= acc_commit && (idx_i == IDX_W'(IX_DCFL));
    end
  end

  a_r2_rsp_next: assert property (@(posedge clk) disable iff (!rst_n)
    rd_i |=> rsp_valid_o);
  a_r2_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_o && err_o) |-> (rdata_o == '0));
  a_r9_dual_access: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && wr_i) |=> err_o);
  a_r9_ro_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && cur_kind == K_RO) |=> err_o);
  a_r8_second_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && cur_kind == K_ONCE && once_set) |=> (err_o && $stable(slot_q[IX_CYCCTL])));
  a_r10_flush_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tlb_flush_o, icache_flush_o, dcache_flush_o}));
  a_r10_flush_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tlb_flush_o) |-> $past(wr_i && !rd_i));

endmodule

// File: tb/icr_file_tb_top.sv
module icr_file_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] PAL_RST = 64'h0000_0000_2000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  idx_i = '0;
  logic [63:0] wdata_i = '0;
  logic        wr_i = 1'b0, rd_i = 1'b0;
  logic [31:0] cycle_i = '0;
  logic [63:0] rdata_o;
  logic        rsp_valid_o, err_o, tlb_flush_o, icache_flush_o, dcache_flush_o;

  int nvec = 0, nbad = 0;
  bit done = 1'b0;
  logic [63:0] model [64];

  icr_file #(.IDX_W(6), .PAL_BASE_RST(PAL_RST)) dut_i (
    .clk(clk), .rst_n(rst_n), .idx_i(idx_i), .wdata_i(wdata_i),
    .wr_i(wr_i), .rd_i(rd_i), .cycle_i(cycle_i), .rdata_o(rdata_o),
    .rsp_valid_o(rsp_valid_o), .err_o(err_o), .tlb_flush_o(tlb_flush_o),
    .icache_flush_o(icache_flush_o), .dcache_flush_o(dcache_flush_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // kinds: 0 store, 1 clear, 2 read-only, 3 counter, 4 one-shot, 5 write-only, 6 undefined
  function automatic int bkind(int i);
    if (i == 22 || i == 23) return 1;
    if (i == 24 || i == 25) return 2;
    if (i == 26) return 3;
    if (i == 27) return 4;
    if (i >= 28 && i <= 30) return 5;
    if (i >= 31) return 6;
    return 0;
  endfunction

  function automatic logic [63:0] bmask(int i);
    case (i)
      10: return 64'hFFFF_FFFF_FFFF_FFFD;
      11, 12: return 64'h0F;
      13, 14: return 64'h18;
      15: return 64'h00FF_FFFF_0300;
      16, 17: return 64'hFFFF_FFFF_C000_0000;
      18, 19: return 64'h3F;
      20: return 64'h7F0;
      21: return 64'hFE00_0000_0000_0000;
      26: return 64'hFFFF_FFFF_0000_0000;
      default: return '1;
    endcase
  endfunction

  function automatic string btag(int i);
    case (bkind(i))
      0: return (i <= 9) ? "R3" : (i == 10) ? "R5" : "R4";
      1: return "R6";
      3: return "R7";
      4: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(bit rd, bit wr, int idx, logic [63:0] d, logic [31:0] cyc, string tov);
    int k;
    bit e_err;
    logic [63:0] e_rd;
    string tg;
    @(negedge clk);
    check(!rsp_valid_o && !tlb_flush_o && !icache_flush_o && !dcache_flush_o, "R10",
          {60'd0, rsp_valid_o, tlb_flush_o, icache_flush_o, dcache_flush_o}, 64'd0);
    rd_i = rd; wr_i = wr; idx_i = 6'(idx); wdata_i = d; cycle_i = cyc;
    k = bkind(idx);
    tg = (tov != "") ? tov : btag(idx);
    e_err = (rd && wr) || (k == 6 && (rd || wr)) || (wr && k == 2) || (rd && k == 5)
            || (wr && k == 4 && model[27] != 0);
    e_rd = e_err ? 64'd0 : (k == 3) ? {model[26][63:32], cyc} : model[idx];
    if (wr && !e_err) begin
      if (k == 1) model[idx] = '0;
      else if (k == 4) model[idx] = 64'd1;
      else if (k != 5) model[idx] = d & bmask(idx);
    end
    @(negedge clk);
    check(err_o == e_err, e_err ? "R9" : tg, {63'd0, err_o}, {63'd0, e_err});
    check(rsp_valid_o == rd, "R2", {63'd0, rsp_valid_o}, {63'd0, rd});
    if (rd) check(rdata_o == e_rd, e_err ? "R2" : tg, rdata_o, e_rd);
    check({tlb_flush_o, icache_flush_o, dcache_flush_o} ==
          {wr && !e_err && idx == 28, wr && !e_err && idx == 29, wr && !e_err && idx == 30},
          "R10", {61'd0, tlb_flush_o, icache_flush_o, dcache_flush_o},
          {61'd0, wr && !e_err && idx == 28, wr && !e_err && idx == 29, wr && !e_err && idx == 30});
    rd_i = 1'b0; wr_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 64; i++) model[i] = '0;
    model[8] = PAL_RST;
    model[9] = 64'h6;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: outputs quiet after reset, then every register at its reset value
    check(rdata_o == 0 && !err_o && !rsp_valid_o, "R1", rdata_o, 64'd0);
    for (int i = 0; i < 64; i++)
      if (bkind(i) != 5) access(1'b1, 1'b0, i, '0, 32'h0000_0100 + 32'(i), "R1");

    // directed corners: all-ones into every defined index, read back
    for (int i = 0; i < 31; i++) begin
      access(1'b0, 1'b1, i, '1, 32'd0, "");
      if (bkind(i) != 5) access(1'b1, 1'b0, i, '0, 32'hCAFE_0000 + 32'(i), "");
    end
    access(1'b0, 1'b1, 27, 64'h55, 32'd0, "R8");
    access(1'b1, 1'b0, 27, '0, 32'd0, "R8");
    access(1'b0, 1'b1, 26, 64'h1234_5678_9ABC_DEF0, 32'd0, "R7");
    access(1'b1, 1'b0, 26, '0, 32'hCAFE_0001, "R7");
    access(1'b0, 1'b1, 22, 64'hDEAD_BEEF, 32'd0, "R6");
    access(1'b1, 1'b0, 22, '0, 32'd0, "R6");
    access(1'b1, 1'b1, 3, 64'h77, 32'd0, "R9");
    access(1'b1, 1'b0, 3, '0, 32'd0, "R9");
    access(1'b0, 1'b1, 24, 64'h99, 32'd0, "R9");
    access(1'b1, 1'b0, 24, '0, 32'd0, "R9");
    access(1'b1, 1'b0, 63, '0, 32'd0, "R9");
    access(1'b0, 1'b1, 40, 64'h1, 32'd0, "R9");
    access(1'b0, 1'b1, 10, 64'hFFFF_FFFF_FFFF_FFFE, 32'd0, "R5");
    access(1'b1, 1'b0, 10, '0, 32'd0, "R5");

    // constrained random traffic
    for (int n = 0; n < 2500; n++) begin
      int idx;
      int op;
      logic [63:0] d;
      idx = ($urandom % 4 != 0) ? int'($urandom % 31) : int'($urandom % 64);
      op  = int'($urandom % 8);
      d   = {$urandom, $urandom};
      access(op >= 4, op < 4 || op == 7, idx, d, $urandom, "");
    end

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

endmodule